// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and a calendar for a real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second strobe starts an update cycle. An update-in-progress status bit is raised for a fixed number of clock cycles, which warns the host. At the end of that window the whole time advances by one second, with every carry resolved at once, and a single-cycle update-ended pulse goes out to the interrupt flag logic.

The host reads and writes byte registers by address. Two mode bits choose how every time field is encoded on the bus: binary or packed BCD, and 24-hour or 12-hour with a PM flag. The time is held internally in binary. Changing a mode bit therefore changes only the presentation and never the time itself. A set bit freezes the counters. While it is high, the host can load all fields without an update landing part-way through the load. Clearing it resumes counting from the loaded time.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00 (address 0x0), minutes 0x00 (0x2), hours 0x00 (0x4), day of week 0x01 (0x6), day of month 0x01 (0x7), month 0x01 (0x8), year 0x00 (0x9), status 0x00 (0xA) and control 0x02 (0xB), and `uf_o` is 0.
- R2: With the set bit clear and no update pending, a one-cycle pulse on `sec_tick_i` sets status bit 7 (update in progress) from the next cycle on. After UPD_CYCLES cycles the time advances by exactly one second and the status bit reads 0 again.
- R3: `uf_o` is high for exactly one cycle, the cycle right after the increment is applied. At no other time is it high.
- R4: Carries resolve in one update. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and advance both day of week (7 wraps to 1) and day of month. Day of month wraps to 1 past the month length and carries into the month. Month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 00.
- R5: Months 4, 6, 9 and 11 have 30 days, and February has 29 days when year mod 4 is 0 and 28 days otherwise. All other months have 31 days.
- R6: Control bit 2 selects the encoding of every time register on reads and writes. A value of 1 selects binary. A value of 0 selects BCD, with the tens digit in bits 7:4 and the units in bits 3:0. Changing this bit changes the read value but not the stored time.
- R7: Control bit 1 set to 1 gives hours 0 to 23. Set to 0, it gives a 12-hour form: bits 6:0 hold 1 to 12 in the current encoding and bit 7 is 1 for PM, so hour 0 reads as 12 AM and hour 12 as 12 PM. Writes use the same form.
- R8: While control bit 7 (set) is 1, strobes are ignored and no update runs or completes. Raising it while an update is pending abandons that update. Writes to time registers take effect only while the set bit is already 1 and are ignored otherwise.
- R9: If a control write raising the set bit lands in the same cycle in which a pending update would complete, the write wins: the time does not advance and `uf_o` stays 0.
- R10: A strobe that arrives while an update is pending is ignored, so the time advances by one second only.
- R11: The status register is read-only, and writes to it have no effect. Addresses with no register (for example 0x1) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-second strobe, one cycle wide |
| wr_en_i | input | 1 | Host write enable |
| addr_i | input | ADDR_W | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for `addr_i`, combinational |
| uf_o | output | 1 | Update-ended pulse |

## Verification
The set bit and the completion of an update can fall in the same cycle. The bench provokes this by starting an update and timing a control write so that the write is sampled on the very edge at which the counter reaches zero. It then judges that `uf_o` stays low in the following cycle and that every time register still reads the loaded value. A second pair of events, a strobe arriving during a pending update, is provoked a few cycles into the window and judged by a single one-second advance.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned DATA_W = 8;

  // register addresses; the host map depends on these
  localparam int unsigned ADR_SEC  = 0;
  localparam int unsigned ADR_MIN  = 2;
  localparam int unsigned ADR_HR   = 4;
  localparam int unsigned ADR_DOW  = 6;
  localparam int unsigned ADR_DOM  = 7;
  localparam int unsigned ADR_MON  = 8;
  localparam int unsigned ADR_YR   = 9;
  localparam int unsigned ADR_STAT = 10;
  localparam int unsigned ADR_CTL  = 11;

  // control / status bit positions
  localparam int unsigned CTL_SET  = 7;
  localparam int unsigned CTL_BIN  = 2;
  localparam int unsigned CTL_H24  = 1;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    byte_t yr;
    byte_t mon;
    byte_t dom;
    byte_t dow;
    byte_t hr;
    byte_t min;
    byte_t sec;
  } rtc_time_t;

  function automatic byte_t bin2bcd(input byte_t v);
    return ((v / 8'd10) << 4) | (v % 8'd10);
  endfunction

  function automatic byte_t bcd2bin(input byte_t b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic byte_t month_len(input byte_t mon, input byte_t yr);
    byte_t n;
    case (mon)
      8'd2:                      n = ((yr % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   n = 8'd30;
      default:                   n = 8'd31;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int unsigned UPD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_tick_i,
  input  logic hold_i,
  output logic uip_o,
  output logic fire_o
);

  localparam int unsigned CNT_W = (UPD_CYCLES > 2) ? $clog2(UPD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UPD_CYCLES - 1);

  logic             uip_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uip_q <= 1'b0;
      cnt_q <= '0;
    end else if (hold_i) begin
      uip_q <= 1'b0;
      cnt_q <= '0;
    end else if (uip_q) begin
      if (cnt_q == '0) uip_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (sec_tick_i) begin
      uip_q <= 1'b1;
      cnt_q <= CNT_LAST;
    end
  end

  assign uip_o  = uip_q;
  assign fire_o = uip_q && (cnt_q == '0) && !hold_i;

endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_cal_pkg::*;
(
  input  rtc_time_t cur_i,
  output rtc_time_t nxt_o
);

  byte_t mlen;

  assign mlen = month_len(cur_i.mon, cur_i.yr);

  // full carry chain resolved combinationally
  always_comb begin
    nxt_o = cur_i;
    if (cur_i.sec >= 8'd59) begin
      nxt_o.sec = 8'd0;
      if (cur_i.min >= 8'd59) begin
        nxt_o.min = 8'd0;
        if (cur_i.hr >= 8'd23) begin
          nxt_o.hr  = 8'd0;
          nxt_o.dow = (cur_i.dow >= 8'd7) ? 8'd1 : cur_i.dow + 8'd1;
          if (cur_i.dom >= mlen) begin
            nxt_o.dom = 8'd1;
            if (cur_i.mon >= 8'd12) begin
              nxt_o.mon = 8'd1;
              nxt_o.yr  = (cur_i.yr >= 8'd99) ? 8'd0 : cur_i.yr + 8'd1;
            end else begin
              nxt_o.mon = cur_i.mon + 8'd1;
            end
          end else begin
            nxt_o.dom = cur_i.dom + 8'd1;
          end
        end else begin
          nxt_o.hr = cur_i.hr + 8'd1;
        end
      end else begin
        nxt_o.min = cur_i.min + 8'd1;
      end
    end else begin
      nxt_o.sec = cur_i.sec + 8'd1;
    end
  end

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             wdata_i,
  input  rtc_time_t         time_i,
  input  logic              set_i,
  input  logic              bin_i,
  input  logic              h24_i,
  input  logic              uip_i,
  output byte_t             rdata_o,
  output byte_t             wr_val_o
);

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(ADR_SEC);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(ADR_MIN);
  localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(ADR_HR);
  localparam logic [ADDR_W-1:0] A_DOW  = ADDR_W'(ADR_DOW);
  localparam logic [ADDR_W-1:0] A_DOM  = ADDR_W'(ADR_DOM);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(ADR_MON);
  localparam logic [ADDR_W-1:0] A_YR   = ADDR_W'(ADR_YR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(ADR_CTL);

  function automatic byte_t enc(input byte_t v, input logic bin);
    return bin ? v : bin2bcd(v);
  endfunction

  function automatic byte_t dec(input byte_t v, input logic bin);
    return bin ? v : bcd2bin(v);
  endfunction

  byte_t h12, hr_enc, rd_hr, wv, w12;
  logic  pm;

  // hour presentation
  always_comb begin
    pm     = time_i.hr >= 8'd12;
    h12    = (time_i.hr == 8'd0)  ? 8'd12 :
             (time_i.hr > 8'd12)  ? time_i.hr - 8'd12 : time_i.hr;
    hr_enc = enc(h24_i ? time_i.hr : h12, bin_i);
    rd_hr  = h24_i ? hr_enc : {pm, hr_enc[6:0]};
  end

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = enc(time_i.sec, bin_i);
      A_MIN:   rdata_o = enc(time_i.min, bin_i);
      A_HR:    rdata_o = rd_hr;
      A_DOW:   rdata_o = enc(time_i.dow, bin_i);
      A_DOM:   rdata_o = enc(time_i.dom, bin_i);
      A_MON:   rdata_o = enc(time_i.mon, bin_i);
      A_YR:    rdata_o = enc(time_i.yr, bin_i);
      A_STAT:  rdata_o = {uip_i, 7'd0};
      A_CTL:   rdata_o = {set_i, 4'd0, bin_i, h24_i, 1'b0};
      default: rdata_o = '0;
    endcase
  end

  // write decode into binary
  always_comb begin
    wv  = dec(wdata_i, bin_i);
    w12 = dec({1'b0, wdata_i[6:0]}, bin_i);
    if (addr_i == A_HR && !h24_i)
      wr_val_o = ((w12 == 8'd12) ? 8'd0 : w12) + (wdata_i[7] ? 8'd12 : 8'd0);
    else
      wr_val_o = wv;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned UPD_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              uf_o
);

  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(ADR_SEC);
  localparam logic [ADDR_W-1:0] A_MIN = ADDR_W'(ADR_MIN);
  localparam logic [ADDR_W-1:0] A_HR  = ADDR_W'(ADR_HR);
  localparam logic [ADDR_W-1:0] A_DOW = ADDR_W'(ADR_DOW);
  localparam logic [ADDR_W-1:0] A_DOM = ADDR_W'(ADR_DOM);
  localparam logic [ADDR_W-1:0] A_MON = ADDR_W'(ADR_MON);
  localparam logic [ADDR_W-1:0] A_YR  = ADDR_W'(ADR_YR);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADR_CTL);

  localparam rtc_time_t TIME_RST = '{yr: 8'd0, mon: 8'd1, dom: 8'd1, dow: 8'd1,
                                     hr: 8'd0, min: 8'd0, sec: 8'd0};

  rtc_time_t time_q, time_nxt;
  logic      set_q, bin_q, h24_q, uf_q;
  logic      ctl_wr, set_wr, hold, uip, upd_fire, time_wr;
  byte_t     wr_val;

  assign ctl_wr  = wr_en_i && (addr_i == A_CTL);
  assign set_wr  = ctl_wr && wdata_i[CTL_SET];
  assign hold    = set_q || set_wr;
  assign time_wr = wr_en_i && set_q;

  rtc_upd_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_i (sec_tick_i),
    .hold_i     (hold),
    .uip_o      (uip),
    .fire_o     (upd_fire)
  );

  rtc_time_adv u_adv (
    .cur_i (time_q),
    .nxt_o (time_nxt)
  );

  rtc_host_port #(.ADDR_W(ADDR_W)) u_port (
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .time_i   (time_q),
    .set_i    (set_q),
    .bin_i    (bin_q),
    .h24_i    (h24_q),
    .uip_i    (uip),
    .rdata_o  (rdata_o),
    .wr_val_o (wr_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= TIME_RST;
    end else if (upd_fire) begin
      time_q <= time_nxt;
    end else if (time_wr) begin
      case (addr_i)
        A_SEC:   time_q.sec <= wr_val;
        A_MIN:   time_q.min <= wr_val;
        A_HR:    time_q.hr  <= wr_val;
        A_DOW:   time_q.dow <= wr_val;
        A_DOM:   time_q.dom <= wr_val;
        A_MON:   time_q.mon <= wr_val;
        A_YR:    time_q.yr  <= wr_val;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else if (ctl_wr) begin
      set_q <= wdata_i[CTL_SET];
      bin_q <= wdata_i[CTL_BIN];
      h24_q <= wdata_i[CTL_H24];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uf_q <= 1'b0;
    else         uf_q <= upd_fire;
  end

  assign uf_o = uf_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uip_i,
  input logic       fire_i,
  input logic       set_i,
  input logic       uf_i,
  input logic       twr_i,
  input logic [7:0] sec_i
);

  // R8: set bit blocks completion
  a_r8_set_blocks_uf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !uf_i);

  // R2: increment only after an update-in-progress window, which then ends
  a_r2_uf_after_uip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |-> ($past(uip_i) && !uip_i));

  // R3: update-ended pulse is one cycle wide
  a_r3_uf_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> !uf_i);

  // R2: plain second step
  a_r2_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_i && $past(sec_i) < 8'd59) |-> (sec_i == $past(sec_i) + 8'd1));

  // R4: seconds wrap
  a_r4_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_i && $past(sec_i) == 8'd59) |-> (sec_i == 8'd0));

  // R8: time holds unless updated or written
  a_r8_time_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(fire_i) && !$past(twr_i)) |-> $stable(sec_i));

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .uip_i  (uip),
  .fire_i (upd_fire),
  .set_i  (set_q),
  .uf_i   (uf_o),
  .twr_i  (time_wr),
  .sec_i  (time_q.sec)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;

  localparam int UPD = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sec_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       uf;

  int n_chk = 0;
  int n_err = 0;

  // model
  int m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr;
  bit m_bin, m_h24;

  always #2.5 clk = ~clk;

  rtc_calendar #(.ADDR_W(4), .UPD_CYCLES(UPD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sec_tick_i(sec_tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .uf_o(uf)
  );

  function automatic logic [7:0] b_enc(int v);
    return m_bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] b_hour(int h);
    int h12;
    logic [7:0] e;
    if (m_h24) return b_enc(h);
    h12 = (h == 0) ? 12 : (h > 12 ? h - 12 : h);
    e = b_enc(h12);
    return {(h >= 12), e[6:0]};
  endfunction

  function automatic int b_mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] b_ctl(bit set);
    return {set, 4'd0, m_bin, m_h24, 1'b0};
  endfunction

  task automatic m_tick();
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (m_hr < 23) begin m_hr++; return; end
    m_hr = 0;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_dom < b_mlen(m_mon, m_yr)) begin m_dom++; return; end
    m_dom = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    m_yr = (m_yr == 99) ? 0 : m_yr + 1;
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_all(string tag);
    logic [7:0] d;
    rd(4'h0, d); chk({tag, " sec"},  d, b_enc(m_sec));
    rd(4'h2, d); chk({tag, " min"},  d, b_enc(m_min));
    rd(4'h4, d); chk({tag, " hour"}, d, b_hour(m_hr));
    rd(4'h6, d); chk({tag, " dow"},  d, b_enc(m_dow));
    rd(4'h7, d); chk({tag, " dom"},  d, b_enc(m_dom));
    rd(4'h8, d); chk({tag, " mon"},  d, b_enc(m_mon));
    rd(4'h9, d); chk({tag, " year"}, d, b_enc(m_yr));
  endtask

  task automatic set_time(int yr, int mon, int dom, int dow, int hr, int mi, int s);
    m_yr = yr; m_mon = mon; m_dom = dom; m_dow = dow; m_hr = hr; m_min = mi; m_sec = s;
    wr(4'hB, b_ctl(1'b1));
    wr(4'h0, b_enc(s));
    wr(4'h2, b_enc(mi));
    wr(4'h4, b_hour(hr));
    wr(4'h6, b_enc(dow));
    wr(4'h7, b_enc(dom));
    wr(4'h8, b_enc(mon));
    wr(4'h9, b_enc(yr));
    wr(4'hB, b_ctl(1'b0));
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  // full update: R2 uip window, R3 pulse
  task automatic do_second(string tag);
    logic [7:0] d;
    pulse_tick();
    addr = 4'hA;
    #1 chk({tag, " R2 uip high"}, rdata, 8'h80);
    repeat (UPD - 1) @(negedge clk);
    #1 chk({tag, " R2 uip before end"}, rdata, 8'h80);
    chk({tag, " R3 uf low before end"}, {7'd0, uf}, 8'h00);
    @(negedge clk);
    #1 chk({tag, " R3 uf pulse"}, {7'd0, uf}, 8'h01);
    chk({tag, " R2 uip cleared"}, rdata, 8'h00);
    m_tick();
    rd(4'hA, d);
    chk({tag, " R3 uf one cycle"}, {7'd0, uf}, 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    m_bin = 0; m_h24 = 1;
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk_all("R1 reset");
    rd(4'hA, d); chk("R1 status", d, 8'h00);
    rd(4'hB, d); chk("R1 ctrl", d, 8'h02);
    chk("R1 uf", {7'd0, uf}, 8'h00);

    // R2 basic advance
    do_second("R2 basic");
    chk_all("R2 basic");

    // R4 full rollover, BCD
    set_time(99, 12, 31, 7, 23, 59, 59);
    do_second("R4 rollover");
    chk_all("R4 rollover");

    // R5 month lengths
    set_time(23, 2, 28, 3, 23, 59, 59); do_second("R5 feb28 common"); chk_all("R5 feb28 common");
    set_time(24, 2, 28, 3, 23, 59, 59); do_second("R5 feb28 leap");   chk_all("R5 feb28 leap");
    set_time(24, 2, 29, 4, 23, 59, 59); do_second("R5 feb29 leap");   chk_all("R5 feb29 leap");
    set_time(24, 4, 30, 2, 23, 59, 59); do_second("R5 apr30");        chk_all("R5 apr30");
    set_time(24, 5, 30, 2, 23, 59, 59); do_second("R5 may30");        chk_all("R5 may30");

    // R6 encoding switch without changing time
    set_time(45, 11, 17, 5, 14, 37, 59);
    rd(4'h0, d); chk("R6 bcd sec", d, 8'h59);
    m_bin = 1; wr(4'hB, b_ctl(1'b0));
    rd(4'h0, d); chk("R6 bin sec", d, 8'h3B);
    chk_all("R6 bin all");
    m_bin = 0; wr(4'hB, b_ctl(1'b0));
    chk_all("R6 bcd all");

    // R7 12-hour form
    m_h24 = 0;
    set_time(10, 1, 1, 1, 0, 0, 0);
    rd(4'h4, d); chk("R7 midnight", d, 8'h12);
    set_time(10, 1, 1, 1, 12, 0, 0);
    rd(4'h4, d); chk("R7 noon", d, 8'h92);
    set_time(10, 1, 1, 1, 13, 0, 0);
    rd(4'h4, d); chk("R7 1pm", d, 8'h81);
    wr(4'hB, b_ctl(1'b1));
    wr(4'h4, 8'h91);
    m_hr = 23; m_h24 = 1;
    wr(4'hB, b_ctl(1'b0));
    rd(4'h4, d); chk("R7 11pm as 24h", d, 8'h23);
    set_time(10, 1, 1, 1, 11, 59, 59); m_h24 = 0; wr(4'hB, b_ctl(1'b0));
    do_second("R7 to noon"); chk_all("R7 to noon");
    m_h24 = 1; wr(4'hB, b_ctl(1'b0));

    // R8 writes ignored with set clear
    set_time(20, 6, 15, 2, 8, 30, 10);
    wr(4'h0, 8'h33);
    wr(4'h9, 8'h77);
    chk_all("R8 write ignored");

    // R8 strobe ignored while set
    wr(4'hB, b_ctl(1'b1));
    pulse_tick();
    addr = 4'hA;
    #1 chk("R8 no uip while set", rdata, 8'h00);
    repeat (UPD + 4) @(negedge clk);
    wr(4'hB, b_ctl(1'b0));
    chk_all("R8 frozen");

    // R8 raise set mid-update abandons it
    pulse_tick();
    repeat (4) @(negedge clk);
    wr(4'hB, b_ctl(1'b1));
    wr(4'hB, b_ctl(1'b0));
    repeat (UPD + 4) @(negedge clk);
    rd(4'hA, d); chk("R8 abandoned uip", d, 8'h00);
    chk_all("R8 abandoned");

    // R9 set write on the completion edge
    set_time(33, 3, 3, 3, 3, 3, 59);
    pulse_tick();
    repeat (UPD - 1) @(negedge clk);
    wr_en = 1'b1; addr = 4'hB; wdata = b_ctl(1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R9 no uf on collision", {7'd0, uf}, 8'h00);
    @(negedge clk);
    #1 chk("R9 no uf after", {7'd0, uf}, 8'h00);
    chk_all("R9 time held");
    wr(4'hB, b_ctl(1'b0));

    // R10 second strobe during pending update
    pulse_tick();
    repeat (5) @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    repeat (2 * UPD + 4) @(negedge clk);
    m_tick();
    chk_all("R10 single advance");

    // R11 status read-only, unmapped address
    wr(4'hA, 8'hFF);
    rd(4'hA, d); chk("R11 status ro", d, 8'h00);
    rd(4'h1, d); chk("R11 unmapped", d, 8'h00);
    rd(4'hF, d); chk("R11 unmapped hi", d, 8'h00);

    // random sweep, R4 R5 R6 R7
    for (int i = 0; i < 60; i++) begin
      int yr, mon, dom, dow, hr, mi, s;
      m_bin = $urandom % 2;
      m_h24 = $urandom % 2;
      yr  = ($urandom % 4 == 0) ? 99 : $urandom % 100;
      mon = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
      dom = ($urandom % 2 == 0) ? b_mlen(mon, yr) : 1 + $urandom % b_mlen(mon, yr);
      dow = 1 + $urandom % 7;
      hr  = ($urandom % 2 == 0) ? 23 : $urandom % 24;
      mi  = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      s   = ($urandom % 4 != 0) ? 59 : $urandom % 60;
      set_time(yr, mon, dom, dow, hr, mi, s);
      do_second("R4 random");
      chk_all("R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #900us;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule